// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI bus address and a PCI cycle type. Three programmable windows do the work. Each window has a base register and a map register. The base register gives the local address range and an enable bit. The map register gives the target bus address and the cycle type. The windows are tried in a fixed order and the lowest-numbered enabled window that contains the address wins. If no window contains it, the block raises a miss flag.

Windows may overlap on purpose. Growing window 0 hides window 1, which software can then point at configuration space. When window 1 is restored and window 0 shrinks again, window 1 becomes visible once more. The translation outputs are purely combinational from the incoming address and the register state.

The window registers sit behind a small write/read port. A lock bit in a system register guards them against stray writes, and only a 16-bit key clears that bit.

Top module: `addr_window_xlat`

## Requirements
- R1: Register offsets 0..2 hold window base registers 0..2 and offsets 4..6 hold map registers 0..2. Each reads back the full 32-bit value last written while unlocked. Offset 3 reads zero.
- R2: When several enabled windows contain the address, the lowest-numbered one supplies the translation, and `xl_win` reports its number.
- R3: A window whose base bit 0 (enable) is clear never matches.
- R4: Base bits [3:2] set the window size: 00 = 16 MB, 01 = 256 MB, 10 = 512 MB, 11 = 1 GB. Base bits [31:24] give the start of the window. Any of those bits that lie below the window size are ignored, so the window is aligned to its size.
- R5: The translated address is the map target (map bits [31:24] shifted up by 24, with the bits below the window size ignored) plus the offset of `lb_addr` within the window.
- R6: When map bit 0 is set, `lb_addr[1:0]` passes through to the translated address. When it is clear, translated bits [1:0] are 00.
- R7: For windows 0 and 1, `xl_type` equals map bits [3:1] (for example 101 for a configuration cycle). Window 2 always reports 001 (I/O).
- R8: When no enabled window contains the address, `xl_miss` is 1 and `xl_addr`, `xl_type` and `xl_win` are all zero.
- R9: After reset, all window registers are zero and the system register (offset 7) reads 0x8000, meaning the lock bit [15] is set.
- R10: Writing 0xA05F in data bits [15:0] to offset 7 clears the lock. While the lock is set, writes to window registers are ignored, and so are writes to offset 7 that do not carry the key.
- R11: While unlocked, a write to offset 7 that does not carry the key sets the lock bit to data bit 15, so the lock can be re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` (combinational) |
| lb_addr | input | 32 | Local-bus address to translate |
| xl_addr | output | 32 | Translated PCI address |
| xl_type | output | 3 | Cycle type of the selected window |
| xl_win | output | 2 | Number of the selected window |
| xl_miss | output | 1 | No enabled window contains `lb_addr` |

## Verification
Addresses are probed in several layouts:
- Disjoint windows separate the three translations and check map bit 0 (pass-through versus zeroed low bits).
- Window 0 is grown to 512 MB and then to 1 GB over windows 1 and 2, which shows whether priority follows window number rather than declaration or the last write.
- Addresses at window edges and in gaps separate range errors from miss handling.
- A base value with bits set below the window size exposes alignment masking.
- Lock, unlock and re-arm sequences are mixed with window writes, and readback plus translation show whether each write landed.

// File: rtl/addr_window_xlat.sv
module addr_window_xlat #(
  parameter int          AW         = 32,
  parameter int          NWIN       = 3,
  parameter int          IO_WIN     = 2,
  parameter int          GRAN_LOG   = 24,
  parameter logic [15:0] UNLOCK_KEY = 16'hA05F,
  parameter logic [2:0]  IO_CODE    = 3'b001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] lb_addr,
  output logic [AW-1:0] xl_addr,
  output logic [2:0]    xl_type,
  output logic [1:0]    xl_win,
  output logic          xl_miss
);
  localparam int IW = 2;
  localparam logic [2:0] SYS_OFF = 3'd7;

  logic [AW-1:0] base_q [NWIN];
  logic [AW-1:0] map_q  [NWIN];
  logic          locked;

  logic [AW-1:0] off_m  [NWIN];
  logic [NWIN-1:0] hit;
  logic [2*NWIN*AW-1:0] win_flat;

  function automatic logic [AW-1:0] offset_mask(input logic [1:0] sz);
    logic [AW-1:0] one;
    one = AW'(1);
    case (sz)
      2'd0:    return (one << GRAN_LOG) - one;
      2'd1:    return (one << (GRAN_LOG + 4)) - one;
      2'd2:    return (one << (GRAN_LOG + 5)) - one;
      default: return (one << (GRAN_LOG + 6)) - one;
    endcase
  endfunction

  wire [AW-1:0] gran_m = (AW'(1) << GRAN_LOG) - AW'(1);

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_win
      assign off_m[w] = offset_mask(base_q[w][3:2]);
      assign hit[w] = base_q[w][0] &&
        ((lb_addr & ~off_m[w]) == (base_q[w] & ~gran_m & ~off_m[w]));
      assign win_flat[(2*w+1)*AW +: AW] = base_q[w];
      assign win_flat[(2*w)*AW +: AW]   = map_q[w];
    end
  endgenerate

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) sel = IW'(i);
  end

  logic [AW-1:0] tgt;
  assign xl_miss = ~|hit;
  assign tgt = (map_q[sel] & ~gran_m & ~off_m[sel]) | (lb_addr & off_m[sel]);

  always_comb begin
    xl_addr = '0;
    xl_type = '0;
    xl_win  = '0;
    if (!xl_miss) begin
      xl_addr = tgt;
      if (!map_q[sel][0]) xl_addr[1:0] = 2'b00;
      xl_type = (sel == IW'(IO_WIN)) ? IO_CODE : map_q[sel][3:1];
      xl_win  = sel;
    end
  end

  wire key_hit = (reg_wdata[15:0] == UNLOCK_KEY);
  wire idx_ok  = (int'(reg_addr[IW-1:0]) < NWIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        map_q[i]  <= '0;
      end
      locked <= 1'b1;
    end else if (reg_we) begin
      if (reg_addr == SYS_OFF) begin
        if (key_hit)      locked <= 1'b0;
        else if (!locked) locked <= reg_wdata[15];
      end else if (!locked && idx_ok) begin
        if (reg_addr[2]) map_q[reg_addr[IW-1:0]]  <= reg_wdata[AW-1:0];
        else             base_q[reg_addr[IW-1:0]] <= reg_wdata[AW-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SYS_OFF)  reg_rdata = {16'h0, locked, 15'h0};
    else if (idx_ok)          reg_rdata = reg_addr[2] ? map_q[reg_addr[IW-1:0]]
                                                      : base_q[reg_addr[IW-1:0]];
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_we && reg_addr != SYS_OFF) |=> $stable(win_flat)); // R10
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == SYS_OFF && reg_wdata[15:0] == UNLOCK_KEY) |=> !locked); // R10
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && reg_we && reg_addr == SYS_OFF && reg_wdata[15:0] != UNLOCK_KEY)
      |=> locked == $past(reg_wdata[15])); // R11
  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |-> (xl_addr == '0 && xl_type == '0 && xl_win == '0)); // R8
  AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_miss |-> base_q[xl_win][0]); // R3
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_miss && !map_q[xl_win][0]) |-> xl_addr[1:0] == 2'b00); // R6
  AST_IO_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_miss && xl_win == IW'(IO_WIN)) |-> xl_type == IO_CODE); // R7
endmodule

// File: tb/addr_window_xlat_tb_top.sv
module addr_window_xlat_tb_top;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, lb_addr = 0, xl_addr;
  logic [2:0] xl_type;
  logic [1:0] xl_win;
  logic xl_miss;
  int checks = 0, bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  addr_window_xlat dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lb_addr(lb_addr), .xl_addr(xl_addr),
    .xl_type(xl_type), .xl_win(xl_win), .xl_miss(xl_miss));

  // behavioural reference model
  longint unsigned mb[3], mm[3];
  bit mlock;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin mb[i] = 0; mm[i] = 0; end
      mlock = 1;
    end else if (reg_we) begin
      if (reg_addr == 7) begin
        if (reg_wdata[15:0] == 16'hA05F) mlock = 0;
        else if (!mlock) mlock = reg_wdata[15];
      end else if (!mlock && reg_addr != 3) begin
        if (reg_addr >= 4) mm[reg_addr-4] = reg_wdata;
        else mb[reg_addr] = reg_wdata;
      end
    end
  end

  function automatic longint unsigned span(input longint unsigned b);
    case ((b >> 2) & 3)
      0: return 64'd16 * 1024 * 1024;
      1: return 64'd256 * 1024 * 1024;
      2: return 64'd512 * 1024 * 1024;
      default: return 64'd1024 * 1024 * 1024;
    endcase
  endfunction

  task automatic chk(input string req, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int hw;
      longint unsigned a, sz, st, ea, rd;
      hw = -1; a = lb_addr; ea = 0;
      for (int i = 0; i < 3; i++) begin
        sz = span(mb[i]);
        st = (mb[i] & 64'hFF00_0000) / sz * sz;
        if (hw < 0 && mb[i][0] && a >= st && a < st + sz) hw = i;
      end
      chk("R8 miss", xl_miss, hw < 0);
      if (hw >= 0) begin
        sz = span(mb[hw]);
        ea = (mm[hw] & 64'hFF00_0000) / sz * sz + (a % sz);
        if (!mm[hw][0]) ea = ea / 4 * 4;
        chk("R2 win", xl_win, hw);
        chk("R5 addr", xl_addr, ea);
        chk("R7 type", xl_type, hw == 2 ? 1 : (mm[hw] >> 1) & 7);
      end
      if (reg_addr == 7) rd = mlock ? 32'h8000 : 0;
      else if (reg_addr == 3) rd = 0;
      else if (reg_addr >= 4) rd = mm[reg_addr-4];
      else rd = mb[reg_addr];
      chk("R1 rdata", reg_rdata, rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #2;
    chk(req, reg_rdata, exp);
  endtask

  task automatic probe(input string req, input logic [31:0] a, input bit m,
                       input logic [31:0] ea, input logic [2:0] et, input logic [1:0] ew);
    @(negedge clk); lb_addr = a; #2;
    chk({req, " miss"}, xl_miss, m);
    chk({req, " addr"}, xl_addr, ea);
    chk({req, " type"}, xl_type, et);
    chk({req, " win"}, xl_win, ew);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R9 lock after reset", 7, 32'h8000);
    rd("R9 base0 after reset", 0, 0);
    probe("R8 reset miss", 32'h4123_4567, 1, 0, 0, 0);
    wr(0, 32'h4000_0005);
    rd("R10 locked write ignored", 0, 0);
    wr(7, 32'h0000_1234);
    rd("R10 non-key sys ignored", 7, 32'h8000);
    wr(7, 32'h0000_A05F);
    rd("R10 key unlocks", 7, 0);
    wr(0, 32'h4000_0005); wr(4, 32'h0000_0006);
    wr(1, 32'h5000_0005); wr(5, 32'h1000_000F);
    wr(2, 32'h6000_0001); wr(6, 32'h0000_000D);
    probe("R5 R6 win0", 32'h4123_4567, 0, 32'h0123_4564, 3'b011, 0);
    probe("R6 win1 pass", 32'h5ABC_DEF3, 0, 32'h1ABC_DEF3, 3'b111, 1);
    probe("R7 win2 io", 32'h6012_3456, 0, 32'h0012_3456, 3'b001, 2);
    probe("R8 gap", 32'h6100_0000, 1, 0, 0, 0);
    probe("R8 below", 32'h3FFF_FFFF, 1, 0, 0, 0);
    probe("R5 edge", 32'h4FFF_FFFF, 0, 32'h0FFF_FFFC, 3'b011, 0);
    wr(0, 32'h4000_0009);
    probe("R2 overlap", 32'h5000_0013, 0, 32'h1000_0010, 3'b011, 0);
    wr(1, 32'h6100_0001); wr(5, 32'h0000_000A);
    probe("R7 config", 32'h6100_0123, 0, 32'h0000_0120, 3'b101, 1);
    wr(0, 32'h4000_0008);
    probe("R3 disabled", 32'h4123_4567, 1, 0, 0, 0);
    wr(0, 32'h4F00_0009);
    probe("R4 aligned", 32'h4000_0004, 0, 32'h0000_0004, 3'b011, 0);
    probe("R4 above", 32'h6000_0000, 0, 32'h0000_0000, 3'b001, 2);
    wr(0, 32'h4000_000D);
    probe("R4 1GB hides win2", 32'h6012_3456, 0, 32'h2012_3454, 3'b011, 0);
    rd("R1 base1", 1, 32'h6100_0001);
    rd("R1 map2", 6, 32'h0000_000D);
    rd("R1 hole", 3, 0);
    wr(7, 32'h0000_8000);
    rd("R11 rearm", 7, 32'h8000);
    wr(0, 32'h0);
    probe("R10 locked keeps win0", 32'h6012_3456, 0, 32'h2012_3454, 3'b011, 0);
    wr(7, 32'h0000_A05F);
    wr(7, 32'h0000_0000);
    rd("R11 stays unlocked", 7, 0);
    wr(0, 32'h0);
    probe("R10 unlocked write lands", 32'h6012_3456, 0, 32'h0012_3456, 3'b001, 2);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      done = 1; checks++; bad++;
      $display("FAIL watchdog got=hang exp=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule